// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block sits on a host I/O bus and offers two 32-bit ports: an address register at port 0xCF8 and a data window at port 0xCFC. Software first writes a packed word into the address register. The word holds an enable bit, a bus number, a device number, a function number and a dword register index. A later access to the data window turns that word into one configuration read or write cycle on a downstream target bus, and the result comes back to the host.

For bus zero the bridge builds a geographic select pattern. Exactly one upper address line, bit (device + 11), is set. The function number goes on bits 10:8 and the register index on bits 7:2. A nonzero bus number instead raises a type-1 flag and passes the packed word downstream unchanged. Before the data phase opens, the select is held for a fixed number of settle cycles. The target then has a bounded window in which to claim the cycle. If no target claims it, the access completes as a master abort and a read returns all ones. Data-window accesses that cannot reach a target complete at once without a downstream cycle. This covers a clear enable bit and a bus-0 device number above 20.

The control is a four-state machine:
- IDLE waits for a host request.
- SETTLE drives the select while the settle counter runs.
- CLAIM holds the data-phase strobe open while the claim counter runs.
- REPLY raises the host acknowledge for one cycle.

The transitions are:
- IDLE→REPLY for address-register accesses and for local data-window completions.
- IDLE→SETTLE when a data-window access launches a cycle.
- SETTLE→CLAIM after SETTLE_CYC cycles.
- CLAIM→REPLY on a claim or when the wait window runs out.
- REPLY→IDLE always.

Top module: `cfg_access_bridge`

## Requirements
- R1: A write to port 0xCF8 stores the data with bits 30:24 and 1:0 forced to zero. A read of port 0xCF8 returns the stored word. In both cases host_ack is high for exactly one cycle, in the cycle after the request is sampled.
- R2: The address register fields are: bit 31 enable, bits 23:16 bus, bits 15:11 device, bits 10:8 function and bits 7:2 register index. For an enabled bus-0 access to a device from 0 to 20, tgt_addr has the single select bit at (device + 11), the function on bits 10:8, the index on bits 7:2, and zeros everywhere else, including bits 1:0. tgt_type1 is low.
- R3: tgt_sel rises in the cycle after a launching data-window request is sampled. tgt_dphase stays low for SETTLE_CYC cycles of tgt_sel and then rises. tgt_addr is stable while tgt_sel is high.
- R4: When tgt_claim is sampled high during the data phase, host_ack follows in the next cycle. host_rdata then equals the tgt_rdata value sampled with the claim, and tgt_sel has dropped.
- R5: If tgt_claim stays low for CLAIM_WAIT data-phase cycles, the access aborts. host_ack then comes SETTLE_CYC + CLAIM_WAIT + 1 cycles after the request, and a read returns 0xFFFFFFFF. A claim in the last allowed cycle still counts.
- R6: A data-window write drives tgt_wr high and tgt_wdata equal to the host write data for the whole cycle.
- R7: With the enable bit clear, a data-window access produces no tgt_sel. It is acknowledged one cycle after the request, and a read returns 0xFFFFFFFF.
- R8: A bus-0 access to a device above 20 produces no tgt_sel. It is acknowledged one cycle after the request and reads 0xFFFFFFFF.
- R9: A nonzero bus number raises tgt_type1 and drives tgt_addr as {8'h00, bus, device, function, index, 2'b00}.
- R10: Requests to any other port, and requests made while a cycle is in progress, produce no acknowledge and leave the address register unchanged.
- R11: After reset, host_ack, tgt_sel and tgt_dphase are low and the address register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, one-cycle pulse |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_port | input | 16 | Host I/O port number |
| host_wdata | input | 32 | Host write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_ack |
| tgt_sel | output | 1 | Downstream configuration cycle active (address and select driven) |
| tgt_dphase | output | 1 | Data phase open, target may claim |
| tgt_type1 | output | 1 | Cycle is for a bus other than zero |
| tgt_wr | output | 1 | Cycle is a write |
| tgt_addr | output | 32 | Downstream address and select lines |
| tgt_wdata | output | 32 | Downstream write data |
| tgt_claim | input | 1 | Target claims the cycle |
| tgt_rdata | input | 32 | Target read data, taken with the claim |

## Verification
Accesses that complete locally, to the address register or to the data window, are due one cycle after the request edge. A launched cycle shows tgt_sel one cycle after the request. tgt_dphase follows SETTLE_CYC cycles later. host_ack follows one cycle after the edge that samples the claim, or SETTLE_CYC + CLAIM_WAIT + 1 cycles after the request on an abort. The bench drives at the falling edge and samples at the next falling edge. A behavioural model advances on each rising edge and is compared on every falling edge. Directed checks also measure the latency in whole cycles from the request to host_ack against these counts, with claims placed at the first, the last allowed and one past the last data-phase cycle.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_CLAIM,
        ST_REPLY
    } cyc_state_t;

    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] func;
        logic [5:0] regi;
    } cfg_fields_t;

    localparam logic [31:0] ADDR_KEEP_MASK = 32'h80FF_FFFC;
    localparam logic [31:0] ALL_ONES       = 32'hFFFF_FFFF;

endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
    import cfg_bridge_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q,
    output cfg_fields_t       fields
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wdata & ADDR_KEEP_MASK;
        end
    end

    always_comb begin
        fields.en   = q[31];
        fields.bus  = q[23:16];
        fields.dev  = q[15:11];
        fields.func = q[10:8];
        fields.regi = q[7:2];
    end

    logic unused_bits;
    assign unused_bits = ^{q[30:24], q[1:0]};

endmodule

// File: rtl/cfg_geo_decode.sv
module cfg_geo_decode
    import cfg_bridge_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int SEL_BASE = 11
) (
    input  cfg_fields_t       fields,
    output logic [DATA_W-1:0] cyc_addr,
    output logic              cyc_type1,
    output logic              launch_ok
);

    localparam int MAX_DEV = DATA_W - 1 - SEL_BASE;
    localparam int SEL_W   = MAX_DEV + 1;
    localparam int PAD_W   = DATA_W - 24;

    logic [SEL_W-1:0] sel_vec;
    logic             dev_in_range;
    logic             bus_zero;

    for (genvar d = 0; d < SEL_W; d++) begin : g_sel
        assign sel_vec[d] = (fields.dev == 5'(d));
    end

    assign dev_in_range = (int'(fields.dev) <= MAX_DEV);
    assign bus_zero     = (fields.bus == 8'h00);

    always_comb begin
        if (bus_zero) begin
            cyc_addr  = {sel_vec, fields.func, fields.regi, 2'b00};
            cyc_type1 = 1'b0;
            launch_ok = fields.en && dev_in_range;
        end else begin
            cyc_addr  = {{PAD_W{1'b0}}, fields.bus, fields.dev,
                         fields.func, fields.regi, 2'b00};
            cyc_type1 = 1'b1;
            launch_ok = fields.en;
        end
    end

endmodule

// File: rtl/cfg_cycle_fsm.sv
module cfg_cycle_fsm
    import cfg_bridge_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int SETTLE_CYC = 4,
    parameter int CLAIM_WAIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic              hit_addr,
    input  logic              hit_data,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] areg_q,
    input  logic [DATA_W-1:0] cyc_addr,
    input  logic              cyc_type1,
    input  logic              launch_ok,
    input  logic              tgt_claim,
    input  logic [DATA_W-1:0] tgt_rdata,
    output logic              areg_we,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic              tgt_sel,
    output logic              tgt_dphase,
    output logic              tgt_type1,
    output logic              tgt_wr,
    output logic [DATA_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_wdata
);

    localparam int CNT_MAX = (SETTLE_CYC > CLAIM_WAIT) ? SETTLE_CYC : CLAIM_WAIT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST   = CNT_W'(CLAIM_WAIT - 1);

    cyc_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] addr_q, wdata_q, rdata_q;
    logic              type1_q, wr_q;
    logic              req_any, req_launch, claim_end, wait_end;

    assign req_any    = host_req && (hit_addr || hit_data);
    assign req_launch = host_req && hit_data && launch_ok;
    assign wait_end   = (cnt_q == WAIT_LAST);
    assign claim_end  = tgt_claim || wait_end;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_launch) begin
                    state_d = ST_SETTLE;
                end else if (req_any) begin
                    state_d = ST_REPLY;
                end
            end
            ST_SETTLE: begin
                if (cnt_q == SETTLE_LAST) begin
                    state_d = ST_CLAIM;
                end
            end
            ST_CLAIM: begin
                if (claim_end) begin
                    state_d = ST_REPLY;
                end
            end
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        host_ack   = (state_q == ST_REPLY);
        tgt_sel    = (state_q == ST_SETTLE) || (state_q == ST_CLAIM);
        tgt_dphase = (state_q == ST_CLAIM);
        areg_we    = (state_q == ST_IDLE) && host_req && hit_addr && host_wr;
        host_rdata = rdata_q;
        tgt_addr   = tgt_sel ? addr_q  : '0;
        tgt_wdata  = tgt_sel ? wdata_q : '0;
        tgt_type1  = tgt_sel && type1_q;
        tgt_wr     = tgt_sel && wr_q;
    end

    // counter and cycle datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            type1_q <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (req_launch) begin
                        addr_q  <= cyc_addr;
                        type1_q <= cyc_type1;
                        wr_q    <= host_wr;
                        wdata_q <= host_wdata;
                    end else if (host_req && hit_addr) begin
                        rdata_q <= areg_q;
                    end else if (host_req && hit_data) begin
                        rdata_q <= ALL_ONES;
                    end
                end
                ST_SETTLE: begin
                    cnt_q <= (cnt_q == SETTLE_LAST) ? '0 : cnt_q + 1'b1;
                end
                ST_CLAIM: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (tgt_claim) begin
                        rdata_q <= tgt_rdata;
                    end else if (wait_end) begin
                        rdata_q <= ALL_ONES;
                    end
                end
                ST_REPLY: cnt_q <= '0;
                default:  cnt_q <= '0;
            endcase
        end
    end

endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge
    import cfg_bridge_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          PORT_W     = 16,
    parameter logic [15:0] ADDR_PORT  = 16'h0CF8,
    parameter logic [15:0] DATA_PORT  = 16'h0CFC,
    parameter int          SEL_BASE   = 11,
    parameter int          SETTLE_CYC = 4,
    parameter int          CLAIM_WAIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [PORT_W-1:0] host_port,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic              tgt_sel,
    output logic              tgt_dphase,
    output logic              tgt_type1,
    output logic              tgt_wr,
    output logic [DATA_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic              tgt_claim,
    input  logic [DATA_W-1:0] tgt_rdata
);

    logic              hit_addr, hit_data, areg_we, cyc_type1, launch_ok;
    logic [DATA_W-1:0] areg_q, cyc_addr;
    cfg_fields_t       fields;

    assign hit_addr = (host_port == PORT_W'(ADDR_PORT));
    assign hit_data = (host_port == PORT_W'(DATA_PORT));

    cfg_addr_reg #(.DATA_W(DATA_W)) u_areg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (areg_we),
        .wdata  (host_wdata),
        .q      (areg_q),
        .fields (fields)
    );

    cfg_geo_decode #(.DATA_W(DATA_W), .SEL_BASE(SEL_BASE)) u_dec (
        .fields    (fields),
        .cyc_addr  (cyc_addr),
        .cyc_type1 (cyc_type1),
        .launch_ok (launch_ok)
    );

    cfg_cycle_fsm #(
        .DATA_W     (DATA_W),
        .SETTLE_CYC (SETTLE_CYC),
        .CLAIM_WAIT (CLAIM_WAIT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_wr    (host_wr),
        .hit_addr   (hit_addr),
        .hit_data   (hit_data),
        .host_wdata (host_wdata),
        .areg_q     (areg_q),
        .cyc_addr   (cyc_addr),
        .cyc_type1  (cyc_type1),
        .launch_ok  (launch_ok),
        .tgt_claim  (tgt_claim),
        .tgt_rdata  (tgt_rdata),
        .areg_we    (areg_we),
        .host_ack   (host_ack),
        .host_rdata (host_rdata),
        .tgt_sel    (tgt_sel),
        .tgt_dphase (tgt_dphase),
        .tgt_type1  (tgt_type1),
        .tgt_wr     (tgt_wr),
        .tgt_addr   (tgt_addr),
        .tgt_wdata  (tgt_wdata)
    );

endmodule

// File: rtl/cfg_access_bridge_chk.sv
module cfg_access_bridge_chk #(
    parameter int DATA_W     = 32,
    parameter int SEL_BASE   = 11,
    parameter int SETTLE_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ack,
    input logic              tgt_sel,
    input logic              tgt_dphase,
    input logic              tgt_type1,
    input logic              tgt_claim,
    input logic [DATA_W-1:0] tgt_addr
);

    logic [15:0] pre_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !tgt_sel) begin
            pre_cnt <= '0;
        end else if (!tgt_dphase) begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    AST_ACK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack); // R1

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sel |-> (tgt_addr[1:0] == 2'b00)); // R2

    AST_SELECT_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel && !tgt_type1) |-> ($countones(tgt_addr[DATA_W-1:SEL_BASE]) == 1)); // R2

    AST_DPHASE_UNDER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_dphase |-> tgt_sel); // R3

    AST_SEL_STARTS_SETTLING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_sel) |-> !tgt_dphase); // R3

    AST_SETTLE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_dphase) |-> (pre_cnt == 16'(SETTLE_CYC))); // R3

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel && $past(tgt_sel)) |-> $stable(tgt_addr)); // R3

    AST_CLAIM_ENDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_dphase && tgt_claim) |=> (host_ack && !tgt_sel)); // R4

    AST_ACK_NOT_DURING_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> !tgt_sel); // R4

endmodule

bind cfg_access_bridge cfg_access_bridge_chk #(
    .DATA_W     (DATA_W),
    .SEL_BASE   (SEL_BASE),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ack   (host_ack),
    .tgt_sel    (tgt_sel),
    .tgt_dphase (tgt_dphase),
    .tgt_type1  (tgt_type1),
    .tgt_claim  (tgt_claim),
    .tgt_addr   (tgt_addr)
);

// File: tb/cfg_access_bridge_tb.sv
module cfg_access_bridge_tb;

    localparam int S = 4;
    localparam int W = 8;
    localparam logic [15:0] PA = 16'h0CF8;
    localparam logic [15:0] PD = 16'h0CFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req = 1'b0, h_wr = 1'b0;
    logic [15:0] h_port = '0;
    logic [31:0] h_wdata = '0;
    logic        host_ack, tgt_sel, tgt_dphase, tgt_type1, tgt_wr;
    logic [31:0] host_rdata, tgt_addr, tgt_wdata;
    logic        tgt_claim = 1'b0;
    logic [31:0] tgt_rdata = '0;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R11";

    always #4 clk = ~clk;

    cfg_access_bridge #(.SETTLE_CYC(S), .CLAIM_WAIT(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(h_req), .host_wr(h_wr),
        .host_port(h_port), .host_wdata(h_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .tgt_sel(tgt_sel), .tgt_dphase(tgt_dphase),
        .tgt_type1(tgt_type1), .tgt_wr(tgt_wr), .tgt_addr(tgt_addr),
        .tgt_wdata(tgt_wdata), .tgt_claim(tgt_claim), .tgt_rdata(tgt_rdata)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // target responder: claims after claim_after data-phase cycles
    bit claim_on = 1'b0;
    int claim_after = 1;
    int dcnt = 0;
    always @(negedge clk) begin
        if (tgt_dphase) begin
            dcnt++;
            tgt_claim = claim_on && (dcnt >= claim_after);
        end else begin
            dcnt = 0;
            tgt_claim = 1'b0;
        end
    end

    // behavioural reference model
    int          m_mode = 0, m_cnt = 0;
    logic [31:0] m_areg = '0, m_rd = '0, m_taddr = '0, m_wdata = '0;
    logic        m_type1 = 0, m_wr = 0, m_rdreq = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_areg = '0; m_rd = '0;
        end else begin
            case (m_mode)
                0: if (h_req && (h_port == PA || h_port == PD)) begin
                    m_rdreq = !h_wr;
                    if (h_port == PA) begin
                        m_rd = m_areg;
                        if (h_wr) m_areg = h_wdata & 32'h80FF_FFFC;
                        m_mode = 3;
                    end else if (!m_areg[31] || (m_areg[23:16] == 0 && m_areg[15:11] > 20)) begin
                        m_rd = 32'hFFFF_FFFF;
                        m_mode = 3;
                    end else begin
                        m_type1 = (m_areg[23:16] != 0);
                        if (m_type1) m_taddr = {8'h00, m_areg[23:2], 2'b00};
                        else m_taddr = (32'h1 << (m_areg[15:11] + 11)) |
                                       {21'h0, m_areg[10:2], 2'b00};
                        m_wr = h_wr; m_wdata = h_wdata;
                        m_mode = 1; m_cnt = 0;
                    end
                end
                1: begin
                    m_cnt++;
                    if (m_cnt == S) begin m_mode = 2; m_cnt = 0; end
                end
                2: begin
                    m_cnt++;
                    if (tgt_claim) begin m_rd = tgt_rdata; m_mode = 3; end
                    else if (m_cnt == W) begin m_rd = 32'hFFFF_FFFF; m_mode = 3; end
                end
                default: m_mode = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, "host_ack", {31'h0, host_ack}, {31'h0, m_mode == 3});
            chk(cur_req, "tgt_sel", {31'h0, tgt_sel}, {31'h0, m_mode == 1 || m_mode == 2});
            chk(cur_req, "tgt_dphase", {31'h0, tgt_dphase}, {31'h0, m_mode == 2});
            if (m_mode == 1 || m_mode == 2) begin
                chk(cur_req, "tgt_addr", tgt_addr, m_taddr);
                chk(cur_req, "tgt_type1", {31'h0, tgt_type1}, {31'h0, m_type1});
                chk(cur_req, "tgt_wr", {31'h0, tgt_wr}, {31'h0, m_wr});
                if (m_wr) chk(cur_req, "tgt_wdata", tgt_wdata, m_wdata);
            end
            if (m_mode == 3 && m_rdreq) chk(cur_req, "host_rdata", host_rdata, m_rd);
        end
    end

    task automatic host_io(input bit wr, input logic [15:0] port, input logic [31:0] wd,
                           output logic [31:0] rd, output int lat);
        @(negedge clk); h_req = 1'b1; h_wr = wr; h_port = port; h_wdata = wd;
        @(negedge clk); h_req = 1'b0; lat = 1;
        while (!host_ack && lat < 60) begin @(negedge clk); lat++; end
        rd = host_rdata;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    bit          saw_sel = 0;
    always @(negedge clk) if (tgt_sel) saw_sel = 1'b1;

    initial begin
        logic [31:0] rd;
        int          lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "ack after reset", {31'h0, host_ack}, 32'h0);
        chk("R11", "sel after reset", {31'h0, tgt_sel}, 32'h0);
        host_io(0, PA, 0, rd, lat);
        chk("R11", "areg after reset", rd, 32'h0);

        // R1 address register masking and latency
        cur_req = "R1";
        host_io(1, PA, 32'hFFFF_0A0F, rd, lat);
        chk("R1", "write latency", lat, 1);
        host_io(0, PA, 0, rd, lat);
        chk("R1", "areg readback", rd, 32'h80FF_0A0C);
        host_io(1, PA, 32'h8000_0A0F, rd, lat);

        // R2/R4 claimed read: dev 1 func 2 idx 3 -> 0x0000120C
        cur_req = "R4";
        claim_on = 1; claim_after = 1; tgt_rdata = 32'h1234_5678;
        host_io(0, PD, 0, rd, lat);
        chk("R4", "claimed read data", rd, 32'h1234_5678);
        chk("R3", "latency claim first cycle", lat, S + 1 + 1);

        // R2 dev 0 func 7 idx 63
        cur_req = "R2";
        host_io(1, PA, 32'h8000_07FC, rd, lat);
        tgt_rdata = 32'h0BAD_CAFE;
        host_io(0, PD, 0, rd, lat);
        chk("R2", "dev0 read data", rd, 32'h0BAD_CAFE);

        // R6 write forwarded
        cur_req = "R6";
        claim_after = 3;
        host_io(1, PD, 32'hCAFE_F00D, rd, lat);
        chk("R6", "write latency", lat, S + 3 + 1);

        // R5 abort and boundary claims
        cur_req = "R5";
        claim_on = 0;
        host_io(0, PD, 0, rd, lat);
        chk("R5", "abort data", rd, 32'hFFFF_FFFF);
        chk("R5", "abort latency", lat, S + W + 1);
        claim_on = 1; claim_after = W; tgt_rdata = 32'h5555_AAAA;
        host_io(0, PD, 0, rd, lat);
        chk("R5", "last-cycle claim data", rd, 32'h5555_AAAA);
        claim_after = W + 1;
        host_io(0, PD, 0, rd, lat);
        chk("R5", "late claim aborts", rd, 32'hFFFF_FFFF);
        claim_after = 1;

        // R2 top select: dev 20 -> bit 31
        cur_req = "R2";
        host_io(1, PA, 32'h800A_0000 & 32'h8000_FFFF | 32'h0000_A000, rd, lat);
        tgt_rdata = 32'h0000_0014;
        host_io(0, PD, 0, rd, lat);
        chk("R2", "dev20 read", rd, 32'h0000_0014);

        // R8 dev 21 unclaimed locally
        cur_req = "R8";
        host_io(1, PA, 32'h8000_A800, rd, lat);
        saw_sel = 0;
        host_io(0, PD, 0, rd, lat);
        chk("R8", "dev21 data", rd, 32'hFFFF_FFFF);
        chk("R8", "dev21 latency", lat, 1);
        chk("R8", "dev21 no sel", {31'h0, saw_sel}, 32'h0);

        // R7 enable clear
        cur_req = "R7";
        host_io(1, PA, 32'h0000_1000, rd, lat);
        saw_sel = 0;
        host_io(0, PD, 0, rd, lat);
        chk("R7", "disabled read", rd, 32'hFFFF_FFFF);
        chk("R7", "disabled latency", lat, 1);
        host_io(1, PD, 32'h1111_2222, rd, lat);
        chk("R7", "disabled write no sel", {31'h0, saw_sel}, 32'h0);

        // R9 type-1 for nonzero bus
        cur_req = "R9";
        host_io(1, PA, 32'h8005_3B10, rd, lat);
        tgt_rdata = 32'h0000_0009;
        host_io(0, PD, 0, rd, lat);
        chk("R9", "type1 read", rd, 32'h0000_0009);

        // R10 other port and busy request ignored
        cur_req = "R10";
        host_io(1, 16'h0080, 32'h8000_0800, rd, lat);
        chk("R10", "other port no ack", lat, 60);
        host_io(0, PA, 0, rd, lat);
        chk("R10", "areg after other port", rd, 32'h8005_3B10);
        claim_after = 2;
        @(negedge clk); h_req = 1; h_wr = 0; h_port = PD;
        @(negedge clk); h_req = 1; h_wr = 1; h_port = PA; h_wdata = 32'h8000_0000;
        @(negedge clk); h_req = 0;
        repeat (S + 6) @(negedge clk);
        host_io(0, PA, 0, rd, lat);
        chk("R10", "areg after busy write", rd, 32'h8005_3B10);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule